// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block watches processor writes that land in the 32 KiB cartridge ROM window and turns them into bank selections. The window is split into four 8 KiB control zones by write address bits [14:13]: one zone switches the external RAM on and off, one zone loads the low five bits of the switchable ROM bank, one zone holds a two-bit value whose meaning depends on a mode bit, and one zone sets that mode bit. In mode 0 the two-bit value supplies ROM bank bits [6:5]. In mode 1 it picks one of four external RAM banks.

The bank registers are clocked. A set of combinational outputs translates a read address into a physical ROM address. Addresses 0x0000-0x3FFF map straight through. Addresses 0x4000-0x7FFF land in the selected bank. The same outputs give a physical RAM address and a qualified read path for the 0xA000-0xBFFF RAM region: while the RAM is switched off, that read path returns 0xFF. The number of physical ROM banks is a parameter (a power of two from 2 to 128). Bank numbers wrap modulo that count.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with address bits [14:13] = 0 sets `ram_en_o` when the byte is 0x0A and clears it when the byte is 0x00. Any other byte leaves it unchanged. The new value is visible after the clock edge that samples the write.
- R2: A write with address bits [14:13] = 1 loads ROM bank bits [4:0] from byte bits [4:0]. If those five bits are all zero, the value 1 is used instead.
- R3: A write to zone 1 leaves ROM bank bits [6:5] unchanged.
- R4: A write with address bits [14:13] = 2 behaves according to the mode. In mode 0, byte bits [1:0] replace ROM bank bits [6:5] and bits [4:0] are kept. In mode 1, byte bits [1:0] become the RAM bank and the ROM bank is unchanged.
- R5: A write with address bits [14:13] = 3 loads the mode from byte bit 0. Writing mode 1 clears ROM bank bits [6:5]. Writing mode 0 sets the RAM bank to 0.
- R6: Every stored ROM bank is ANDed with ROM_BANKS-1, so a request beyond the physical size wraps.
- R7: While reset is held, the outputs settle to the reset state: ROM bank 1, RAM bank 0, RAM disabled and mode 0.
- R8: `rom_sel_o` equals NOT `rd_addr_i[15]`. When `rd_addr_i[14]` is 0, `rom_addr_o` is `rd_addr_i[13:0]`. When it is 1, `rom_addr_o` is the ROM bank times 16384 plus `rd_addr_i[13:0]`.
- R9: `ram_addr_o` is the RAM bank times 8192 plus `rd_addr_i[12:0]`. `ram_rd_en_o` is high only when `rd_addr_i` lies in 0xA000-0xBFFF and the RAM is enabled. `ext_rdata_o` carries `ram_rdata_i` when `ram_rd_en_o` is high and 0xFF otherwise.
- R10: A write is ignored when `wr_en_i` is low or when `wr_addr_i[15]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 8 | Write byte |
| rd_addr_i | input | 16 | Read address to translate |
| ram_rdata_i | input | 8 | Byte returned by the external RAM array |
| rom_bank_o | output | 7 | Current switchable ROM bank |
| ram_bank_o | output | 2 | Current external RAM bank |
| ram_en_o | output | 1 | External RAM enabled |
| mode_o | output | 1 | Current mode bit |
| rom_sel_o | output | 1 | Read address lies in the ROM window |
| rom_addr_o | output | $clog2(ROM_BANKS)+14 | Physical ROM byte address |
| ram_addr_o | output | 15 | Physical RAM byte address |
| ram_rd_en_o | output | 1 | Qualified RAM read |
| ext_rdata_o | output | 8 | RAM read data, or 0xFF when the RAM is not readable |

## Verification
The assertions assume the following about the inputs:
- ROM_BANKS is a power of two no larger than 128.
- Every input is synchronous to `clk`.
- A write is a single-cycle strobe whose address and byte are stable around the sampling edge.

The bench drives every input on the falling edge and keeps the default bank count. This satisfies those assumptions while the stimulus covers every zone, including bytes that fall outside the recognised values and addresses above the ROM window.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int BANK_W  = 7;
  localparam int LO_W    = 5;
  localparam int HI_W    = 2;
  localparam int WIN_AW  = 14;
  localparam int RAM_AW  = 13;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;

  typedef enum logic [1:0] {
    Z_RAMEN = 2'd0,
    Z_ROMLO = 2'd1,
    Z_SHARE = 2'd2,
    Z_MODE  = 2'd3
  } zone_e;

  typedef struct packed {
    logic              valid;
    zone_e             zone;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/cbc_wr_decode.sv
module cbc_wr_decode
  import cbc_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wr_cmd_t           cmd
);
  // Only the lower 32 KiB window carries control writes.
  always_comb begin
    cmd.valid = wr_en && !wr_addr[ADDR_W-1];
    cmd.zone  = zone_e'(wr_addr[ADDR_W-2:ADDR_W-3]);
    cmd.data  = wr_data;
  end
endmodule

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_cmd_t           cmd,
  output logic [BANK_W-1:0] rom_bank,
  output logic [HI_W-1:0]   ram_bank,
  output logic              ram_en,
  output logic              mode
);
  localparam logic [BANK_W-1:0] BANK_MASK = BANK_W'(ROM_BANKS - 1);
  localparam logic [BANK_W-1:0] BANK_RST  = BANK_W'(1);

  logic [BANK_W-1:0] bank_d;
  logic [HI_W-1:0]   ramb_d;
  logic              en_d;
  logic              mode_d;
  logic [LO_W-1:0]   lo_fix;

  always_comb begin
    lo_fix = (cmd.data[LO_W-1:0] == '0) ? LO_W'(1) : cmd.data[LO_W-1:0];
    bank_d = rom_bank;
    ramb_d = ram_bank;
    en_d   = ram_en;
    mode_d = mode;
    if (cmd.valid) begin
      unique case (cmd.zone)
        Z_RAMEN: begin
          if (cmd.data == 8'h0A)      en_d = 1'b1;
          else if (cmd.data == 8'h00) en_d = 1'b0;
        end
        Z_ROMLO: bank_d = {rom_bank[BANK_W-1:LO_W], lo_fix} & BANK_MASK;
        Z_SHARE: begin
          if (!mode) bank_d = {cmd.data[HI_W-1:0], rom_bank[LO_W-1:0]} & BANK_MASK;
          else       ramb_d = cmd.data[HI_W-1:0];
        end
        Z_MODE: begin
          mode_d = cmd.data[0];
          if (cmd.data[0]) bank_d = {{HI_W{1'b0}}, rom_bank[LO_W-1:0]} & BANK_MASK;
          else             ramb_d = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_bank <= BANK_RST;
      ram_bank <= '0;
      ram_en   <= 1'b0;
      mode     <= 1'b0;
    end else begin
      rom_bank <= bank_d;
      ram_bank <= ramb_d;
      ram_en   <= en_d;
      mode     <= mode_d;
    end
  end

  assert_enable_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd.valid && cmd.zone == Z_RAMEN && cmd.data != 8'h0A && cmd.data != 8'h00)
      |=> $stable(ram_en));

  assert_upper_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd.valid && cmd.zone == Z_ROMLO) |=> (rom_bank[BANK_W-1:LO_W] == $past(rom_bank[BANK_W-1:LO_W])));

  assert_rom_frozen_mode1_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd.valid && cmd.zone == Z_SHARE && mode) |=> $stable(rom_bank));

  assert_ram_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd.valid && cmd.zone == Z_MODE && !cmd.data[0]) |=> (ram_bank == '0 && !mode));

  assert_bank_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    ((rom_bank & ~BANK_MASK) == '0));

  assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rom_bank == BANK_RST && ram_bank == '0 && !ram_en && !mode));

  assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd.valid |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en) && $stable(mode)));
endmodule

// File: rtl/cbc_addr_xlate.sv
module cbc_addr_xlate
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 64
) (
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic [$clog2(ROM_BANKS)-1:0]        rom_bank,
  input  logic [HI_W-1:0]                     ram_bank,
  input  logic                                ram_en,
  input  logic [DATA_W-1:0]                   ram_rdata,
  output logic                                rom_sel,
  output logic [$clog2(ROM_BANKS)+WIN_AW-1:0] rom_addr,
  output logic [HI_W+RAM_AW-1:0]              ram_addr,
  output logic                                ram_rd_en,
  output logic [DATA_W-1:0]                   ext_rdata
);
  localparam int ROM_AW = $clog2(ROM_BANKS);

  logic in_ram_region;

  always_comb begin
    rom_sel       = !rd_addr[ADDR_W-1];
    rom_addr      = rd_addr[WIN_AW] ? {rom_bank, rd_addr[WIN_AW-1:0]}
                                    : {{ROM_AW{1'b0}}, rd_addr[WIN_AW-1:0]};
    in_ram_region = (rd_addr[ADDR_W-1:RAM_AW] == 3'b101);
    ram_addr      = {ram_bank, rd_addr[RAM_AW-1:0]};
    ram_rd_en     = in_ram_region && ram_en;
    ext_rdata     = ram_rd_en ? ram_rdata : 8'hFF;
  end

  always_comb begin
    assert_ff_when_off_R9: assert (ram_en || ext_rdata == 8'hFF);
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en_i,
  input  logic [15:0]                          wr_addr_i,
  input  logic [7:0]                           wr_data_i,
  input  logic [15:0]                          rd_addr_i,
  input  logic [7:0]                           ram_rdata_i,
  output logic [6:0]                           rom_bank_o,
  output logic [1:0]                           ram_bank_o,
  output logic                                 ram_en_o,
  output logic                                 mode_o,
  output logic                                 rom_sel_o,
  output logic [$clog2(ROM_BANKS)+13:0]        rom_addr_o,
  output logic [14:0]                          ram_addr_o,
  output logic                                 ram_rd_en_o,
  output logic [7:0]                           ext_rdata_o
);
  localparam int ROM_AW = $clog2(ROM_BANKS);

  wr_cmd_t cmd;

  cbc_wr_decode u_dec (
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .cmd     (cmd)
  );

  cbc_bank_regs #(.ROM_BANKS(ROM_BANKS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .rom_bank (rom_bank_o),
    .ram_bank (ram_bank_o),
    .ram_en   (ram_en_o),
    .mode     (mode_o)
  );

  cbc_addr_xlate #(.ROM_BANKS(ROM_BANKS)) u_xlate (
    .rd_addr   (rd_addr_i),
    .rom_bank  (rom_bank_o[ROM_AW-1:0]),
    .ram_bank  (ram_bank_o),
    .ram_en    (ram_en_o),
    .ram_rdata (ram_rdata_i),
    .rom_sel   (rom_sel_o),
    .rom_addr  (rom_addr_o),
    .ram_addr  (ram_addr_o),
    .ram_rd_en (ram_rd_en_o),
    .ext_rdata (ext_rdata_o)
  );
endmodule

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;
  localparam int NB = 64;
  localparam int AW = $clog2(NB) + 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0, ram_rdata = '0;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic ram_en, mode, rom_sel, ram_rd_en;
  logic [AW-1:0] rom_addr;
  logic [14:0] ram_addr;
  logic [7:0]  ext_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // reference state
  int m_bank = 1, m_ramb = 0, m_en = 0, m_mode = 0;

  always #4 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(NB)) dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .ram_rdata_i(ram_rdata), .rom_bank_o(rom_bank),
    .ram_bank_o(ram_bank), .ram_en_o(ram_en), .mode_o(mode), .rom_sel_o(rom_sel),
    .rom_addr_o(rom_addr), .ram_addr_o(ram_addr), .ram_rd_en_o(ram_rd_en),
    .ext_rdata_o(ext_rdata)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_write(int a, int d);
    int lo;
    if (a >= 'h8000) return;
    case ((a >> 13) & 3)
      0: begin if (d == 'h0A) m_en = 1; else if (d == 0) m_en = 0; end
      1: begin
        lo = d & 'h1F;
        if (lo == 0) lo = 1;
        m_bank = ((m_bank & 'h60) | lo) & (NB - 1);
      end
      2: begin
        if (m_mode == 0) m_bank = (((d & 3) << 5) | (m_bank & 'h1F)) & (NB - 1);
        else m_ramb = d & 3;
      end
      default: begin
        m_mode = d & 1;
        if (m_mode == 1) m_bank = m_bank & 'h1F & (NB - 1);
        else m_ramb = 0;
      end
    endcase
  endtask

  task automatic compare_all(string tag);
    int ra, exp_rom, exp_rd_en;
    ra = int'(rd_addr);
    chk(tag, "rom_bank", int'(rom_bank), m_bank);
    chk(tag, "ram_bank", int'(ram_bank), m_ramb);
    chk(tag, "ram_en", int'(ram_en), m_en);
    chk(tag, "mode", int'(mode), m_mode);
    chk(tag, "rom_sel", int'(rom_sel), (ra < 'h8000) ? 1 : 0);
    if (ra < 'h8000) begin
      exp_rom = (ra < 'h4000) ? (ra & 'h3FFF) : (m_bank * 16384 + (ra & 'h3FFF));
      chk(tag, "rom_addr", int'(rom_addr), exp_rom);
    end
    chk(tag, "ram_addr", int'(ram_addr), m_ramb * 8192 + (ra & 'h1FFF));
    exp_rd_en = (ra >= 'hA000 && ra < 'hC000 && m_en == 1) ? 1 : 0;
    chk(tag, "ram_rd_en", int'(ram_rd_en), exp_rd_en);
    chk(tag, "ext_rdata", int'(ext_rdata), exp_rd_en ? int'(ram_rdata) : 'hFF);
  endtask

  // one clock: drive at the falling edge, update model at the rising edge, compare just after
  task automatic step(bit we, int a, int d, int ra, int rdat, string tag);
    @(negedge clk);
    wr_en = we; wr_addr = 16'(a); wr_data = 8'(d);
    rd_addr = 16'(ra); ram_rdata = 8'(rdat);
    @(posedge clk);
    if (we) model_write(a, d);
    #1;
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    repeat (3) @(posedge clk);
    #1;
    compare_all("R7");
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, 'h4123, 0, "R7");

    // R1 RAM enable control and R9 read qualification
    step(1, 'h0000, 'h0A, 'hA000, 'h5A, "R1");
    step(0, 0, 0, 'hBFFF, 'h33, "R9");
    step(0, 0, 0, 'h9FFF, 'h33, "R9");
    step(0, 0, 0, 'hC000, 'h33, "R9");
    step(1, 'h1FFF, 'h05, 'hA010, 'h77, "R1");
    step(1, 'h0100, 'h00, 'hA010, 'h77, "R1");
    step(1, 'h0000, 'h8A, 'hA010, 'h77, "R1");
    step(1, 'h0000, 'h0A, 'hB000, 'h11, "R1");

    // R2 low bank bits, zero remap
    step(1, 'h2000, 'h00, 'h4000, 0, "R2");
    step(1, 'h3FFF, 'h1F, 'h7FFF, 0, "R2");
    step(1, 'h2000, 'hE0, 'h4001, 0, "R2");
    step(1, 'h2100, 'h07, 'h5555, 0, "R2");

    // R4 mode 0 upper bits, R6 wrap
    step(1, 'h4000, 'h01, 'h4000, 0, "R4");
    step(1, 'h2000, 'h03, 'h4000, 0, "R3");
    step(1, 'h2000, 'h00, 'h7FFF, 0, "R3");
    step(1, 'h5FFF, 'h02, 'h4000, 0, "R6");
    step(1, 'h4000, 'h03, 'h6000, 0, "R6");

    // R5 mode 1 clears upper, R4 mode 1 selects RAM bank
    step(1, 'h6000, 'h01, 'h4000, 0, "R5");
    step(1, 'h4000, 'h03, 'hA123, 'h42, "R4");
    step(1, 'h5000, 'h02, 'hBFFF, 'h43, "R4");
    step(1, 'h6000, 'h00, 'hA123, 'h44, "R5");
    step(1, 'h7FFF, 'hFE, 'hA123, 'h45, "R5");

    // R8 translation corners
    step(0, 0, 0, 'h0000, 0, "R8");
    step(0, 0, 0, 'h3FFF, 0, "R8");
    step(0, 0, 0, 'h4000, 0, "R8");
    step(0, 0, 0, 'h7FFF, 0, "R8");

    // R10 ignored writes
    step(1, 'h8000, 'h00, 'hA000, 'h10, "R10");
    step(1, 'hA000, 'h1C, 'h4000, 0, "R10");
    step(1, 'hE000, 'h01, 'h4000, 0, "R10");
    step(0, 'h2000, 'h09, 'h4000, 0, "R10");
    step(0, 'h0000, 'h00, 'hA000, 'h10, "R10");

    // random mix, tag by the zone exercised
    for (int i = 0; i < 400; i++) begin
      int a, d, ra;
      string tg;
      a  = int'($urandom_range(0, 'hFFFF));
      d  = (($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 0) ? 'h0A : 0)
                                         : int'($urandom_range(0, 255)));
      ra = int'($urandom_range(0, 'hFFFF));
      if (a >= 'h8000) tg = "R10";
      else case ((a >> 13) & 3)
        0: tg = "R1";
        1: tg = "R2";
        2: tg = "R4";
        default: tg = "R5";
      endcase
      step(1, a, d, ra, int'($urandom_range(0, 255)), tg);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule